// File: doc/BRIEF.md
# Oversampled Slow-Clock Regenerator

This block takes a slow, free-running external clock (nominally 2 MHz, 500 ns period) that may carry short spurious pulses. It oversamples that clock with a fast internal clock that is unrelated to it. A pulse is accepted as a real level change only when it persists for a minimum number of consecutive fast samples. From the accepted levels the block rebuilds a clean copy of the slow clock. It is meant for boards where noise couples into a slow clock line and the noise cannot be removed at its origin.

The filter and the synchronizer add some latency. The block pads that latency with a fixed delay line, so that every rebuilt edge appears exactly one nominal input period after the raw edge that caused it. The rebuilt clock therefore stays in phase with the original, to within one fast-clock period.

A period monitor does three things:
- It measures the time between accepted rising edges and raises a lock flag once the measured periods are stable.
- It drops the lock flag when the input stops toggling.
- It holds the rebuilt clock low while the input has stopped.

A one-cycle flag reports each excursion that the filter rejects.

Top module: `slowclk_regen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `clk_clean`, `locked` and `glitch_seen` are all 0.
- R2: A raw level that is seen by fewer than `HOLD_SAMPLES` (4) consecutive fast samples produces no edge on `clk_clean`.
- R3: Each rejected excursion on `clk_raw` raises `glitch_seen` for exactly one fast cycle. An accepted level change never raises it.
- R4: Every accepted raw edge, rising or falling, produces one `clk_clean` edge of the same direction. That edge follows the raw edge by `PERIOD_CYC` fast cycles (500 ns at 100 MHz), plus less than one fast period of sampling phase. No other `clk_clean` edges occur.
- R5: `locked` rises only at an accepted rising edge. It rises at the edge that completes the second consecutive measured rising-to-rising period within `PERIOD_CYC` ± `TOL_CYC` (50 ± 2) fast cycles. The first rising edge after reset or after a stall is never counted as a good period, so lock appears at the third rising edge. A period outside that window clears `locked`.
- R6: If no edge is accepted for `PERIOD_CYC*3/2` (75) fast cycles, two things happen. `locked` goes to 0. `clk_clean` is held at 0 from the next cycle on, until an edge is accepted again.
- R7: A parameter set that leaves no room for the delay line, or that has fewer than two synchronizer stages, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast sampling clock (100 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| clk_raw | input | 1 | Slow external clock, asynchronous to clk_fast |
| clk_clean | output | 1 | Rebuilt slow clock, one nominal period behind clk_raw |
| locked | output | 1 | Measured period is stable |
| glitch_seen | output | 1 | One-cycle pulse for each rejected excursion |

## Verification
The assertions assume that `clk_raw` is free-running. They also assume that its real half-periods are far longer than `HOLD_SAMPLES` fast cycles, and that spurious pulses fall well inside a phase rather than beside a real edge, where they could interrupt the acceptance count.

The stimulus follows these assumptions. It jitters each half-period by only a few nanoseconds. It places every spurious high pulse 80 to 150 ns into the low phase. It keeps all raw transitions off the sampling edge. Each pulse is positioned to straddle a known number of sampling edges (one or three), so the expected number of rejections is exact.

// File: rtl/scr_pkg.sv
package scr_pkg;

   // true when a measured count lies inside nominal +/- tolerance
   function automatic logic scr_in_window(input int meas, input int nom, input int tol);
      return (meas >= nom - tol) && (meas <= nom + tol);
   endfunction

   // counter width able to hold 0..maxval
   function automatic int scr_width(input int maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("scr_sync: STAGES must be at least 2");  // R7
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/scr_debounce.sv
module scr_debounce #(
   parameter int HOLD = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic rise,
   output logic edge_p,
   output logic glitch
);
   import scr_pkg::*;

   localparam int CW = scr_width(HOLD);

   if (HOLD < 1) begin : g_bad_hold
      $error("scr_debounce: HOLD must be at least 1");  // R7
   end

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         level   <= 1'b0;
         run_cnt <= '0;
         rise    <= 1'b0;
         edge_p  <= 1'b0;
         glitch  <= 1'b0;
      end else begin
         rise   <= 1'b0;
         edge_p <= 1'b0;
         glitch <= 1'b0;
         if (din != level) begin
            if (run_cnt == CW'(HOLD - 1)) begin
               level   <= din;
               run_cnt <= '0;
               edge_p  <= 1'b1;
               rise    <= din;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end else begin
            if (run_cnt != '0) glitch <= 1'b1;
            run_cnt <= '0;
         end
      end
   end

   AST_GLITCH_NOT_EDGE: assert property (@(posedge clk) disable iff (rst)
      !(glitch && edge_p)); // R3

   AST_GLITCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      glitch |=> !glitch); // R3

   AST_ACCEPT_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
      (level != $past(level)) |-> ($past(din) == level)); // R2

   if (HOLD >= 2) begin : g_hold_chk
      AST_ACCEPT_HELD_TWO: assert property (@(posedge clk) disable iff (rst)
         $past(level != $past(level)) |-> ($past(din, 2) == $past(level))); // R2
   end
endmodule

// File: rtl/scr_period_mon.sv
module scr_period_mon #(
   parameter int PERIOD_CYC   = 50,
   parameter int TOL_CYC      = 2,
   parameter int LOCK_PERIODS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic rise,
   input  logic edge_p,
   output logic locked,
   output logic stalled
);
   import scr_pkg::*;

   localparam int TIMEOUT_CYC = PERIOD_CYC + PERIOD_CYC / 2;
   localparam int CW          = scr_width(TIMEOUT_CYC);
   localparam int GW          = scr_width(LOCK_PERIODS);

   if (LOCK_PERIODS < 1 || TOL_CYC < 0) begin : g_bad_lock
      $error("scr_period_mon: bad lock parameters");  // R7
   end

   logic [CW-1:0] per_cnt, idle_cnt, idle_nxt;
   logic [GW-1:0] good_cnt;
   logic          meas_ok;

   always_comb begin
      if (edge_p)                          idle_nxt = '0;
      else if (idle_cnt != CW'(TIMEOUT_CYC)) idle_nxt = idle_cnt + 1'b1;
      else                                 idle_nxt = idle_cnt;
      meas_ok = scr_in_window(int'(per_cnt) + 1, PERIOD_CYC, TOL_CYC);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         per_cnt  <= CW'(TIMEOUT_CYC);
         idle_cnt <= CW'(TIMEOUT_CYC);
         stalled  <= 1'b1;
         good_cnt <= '0;
         locked   <= 1'b0;
      end else begin
         idle_cnt <= idle_nxt;
         stalled  <= (idle_nxt == CW'(TIMEOUT_CYC));
         if (rise)                              per_cnt <= '0;
         else if (per_cnt != CW'(TIMEOUT_CYC))  per_cnt <= per_cnt + 1'b1;

         if (idle_nxt == CW'(TIMEOUT_CYC)) begin
            good_cnt <= '0;
            locked   <= 1'b0;
            per_cnt  <= CW'(TIMEOUT_CYC);
         end else if (rise) begin
            if (meas_ok) begin
               if (good_cnt != GW'(LOCK_PERIODS)) good_cnt <= good_cnt + 1'b1;
               locked <= (int'(good_cnt) + 1 >= LOCK_PERIODS);
            end else begin
               good_cnt <= '0;
               locked   <= 1'b0;
            end
         end
      end
   end

   AST_LOCK_AT_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(locked) |-> $past(rise)); // R5

   AST_STALL_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
      stalled |-> !locked); // R6
endmodule

// File: rtl/scr_delay_line.sv
module scr_delay_line #(
   parameter int DEPTH = 44
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);
   if (DEPTH < 0) begin : g_bad_depth
      $error("scr_delay_line: no room left for the delay line");  // R7
   end else if (DEPTH == 0) begin : g_pass
      assign dout = din;
   end else if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (rst) dout <= 1'b0;
         else     dout <= din;
      end
   end else begin : g_shift
      logic [DEPTH-1:0] taps;
      always_ff @(posedge clk) begin
         if (rst) taps <= '0;
         else     taps <= {taps[DEPTH-2:0], din};
      end
      assign dout = taps[DEPTH-1];
   end
endmodule

// File: rtl/slowclk_regen.sv
module slowclk_regen #(
   parameter int PERIOD_CYC   = 50,
   parameter int SYNC_STAGES  = 2,
   parameter int HOLD_SAMPLES = 4,
   parameter int TOL_CYC      = 2,
   parameter int LOCK_PERIODS = 2
) (
   input  logic clk_fast,
   input  logic rst,
   input  logic clk_raw,
   output logic clk_clean,
   output logic locked,
   output logic glitch_seen
);
   // latency budget: SYNC + HOLD - 1 to accept, DELAY stages, 1 output flop
   localparam int DELAY_STAGES = PERIOD_CYC - SYNC_STAGES - HOLD_SAMPLES;

   if (DELAY_STAGES < 0) begin : g_bad_budget
      $error("slowclk_regen: filter latency exceeds one period");  // R7
   end

   logic raw_sync, level, rise, edge_p, stalled, delayed;

   scr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_fast), .rst(rst), .din(clk_raw), .dout(raw_sync));

   scr_debounce #(.HOLD(HOLD_SAMPLES)) u_filt (
      .clk(clk_fast), .rst(rst), .din(raw_sync), .level(level),
      .rise(rise), .edge_p(edge_p), .glitch(glitch_seen));

   scr_period_mon #(.PERIOD_CYC(PERIOD_CYC), .TOL_CYC(TOL_CYC),
                    .LOCK_PERIODS(LOCK_PERIODS)) u_mon (
      .clk(clk_fast), .rst(rst), .rise(rise), .edge_p(edge_p),
      .locked(locked), .stalled(stalled));

   scr_delay_line #(.DEPTH(DELAY_STAGES)) u_dly (
      .clk(clk_fast), .rst(rst), .din(level), .dout(delayed));

   always_ff @(posedge clk_fast) begin
      if (rst) clk_clean <= 1'b0;
      else     clk_clean <= delayed & ~stalled;
   end

   AST_STALL_CLAMP: assert property (@(posedge clk_fast) disable iff (rst)
      stalled |=> !clk_clean); // R6

   AST_GLITCH_QUIET_OUT: assert property (@(posedge clk_fast) disable iff (rst)
      glitch_seen |-> !edge_p); // R3
endmodule

// File: tb/slowclk_regen_test.sv
`timescale 1ns/1ps
module slowclk_regen_test;
   logic clk_fast = 1'b0;
   logic rst      = 1'b1;
   logic clk_raw  = 1'b0;
   logic clk_clean, locked, glitch_seen;

   int n_checks = 0;
   int n_fail   = 0;
   int n_glitch_exp = 0;
   int n_glitch_obs = 0;
   bit mon_on   = 1'b0;
   bit finished = 1'b0;

   typedef struct { longint t; logic lvl; } exp_t;
   exp_t sb[$];

   slowclk_regen uut (
      .clk_fast(clk_fast), .rst(rst), .clk_raw(clk_raw),
      .clk_clean(clk_clean), .locked(locked), .glitch_seen(glitch_seen));

   always #5 clk_fast = ~clk_fast;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_until(input longint t);
      if (t > $time) #(t - $time);
   endtask

   task automatic dodge();
      if ($time % 10 == 5) #1;
   endtask

   // driver: one raw edge, pushed into the scoreboard
   task automatic drive_edge(input logic lvl, output longint t);
      dodge();
      clk_raw = lvl;
      t = $time;
      sb.push_back('{t: t + 500, lvl: lvl});
   endtask

   // spurious high pulse covering nsamp sampling edges
   task automatic inject(input longint at, input int nsamp);
      longint g;
      g = at + ((12 - (at % 10)) % 10);
      wait_until(g);
      clk_raw = 1'b1;
      #(nsamp == 1 ? 8 : 27);
      clk_raw = 1'b0;
      n_glitch_exp++;
   endtask

   // monitor: compare every clean-clock change with the scoreboard head
   logic prev_clean = 1'b0;
   always @(negedge clk_fast) begin
      if (!rst && glitch_seen) n_glitch_obs++;
      if (mon_on && clk_clean !== prev_clean) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 extra output edge", longint'(clk_clean), longint'(prev_clean));
         end else begin
            exp_t e;
            longint d;
            e = sb.pop_front();
            d = $time - e.t;
            check(d >= 5 && d <= 15, "R4 edge delay", d, 10);
            check(clk_clean === e.lvl, "R4 edge level", longint'(clk_clean), longint'(e.lvl));
         end
      end
      prev_clean = clk_clean;
   end

   initial begin
      longint tr, tf;
      repeat (4) @(negedge clk_fast);
      check(clk_clean === 1'b0, "R1 clean in reset", longint'(clk_clean), 0);
      check(locked === 1'b0, "R1 lock in reset", longint'(locked), 0);
      check(glitch_seen === 1'b0, "R1 glitch in reset", longint'(glitch_seen), 0);
      repeat (6) @(negedge clk_fast);
      rst = 1'b0;
      @(negedge clk_fast);
      check(clk_clean === 1'b0 && locked === 1'b0 && glitch_seen === 1'b0,
            "R1 after release", longint'({clk_clean, locked, glitch_seen}), 0);
      mon_on = 1'b1;
      #103;

      for (int i = 0; i < 12; i++) begin
         drive_edge(1'b1, tr);
         #200;
         if (i == 1)
            check(locked === 1'b0, "R5 no lock after one good period", longint'(locked), 0);
         if (i >= 2)
            check(locked === 1'b1, "R5 lock held", longint'(locked), 1);
         wait_until(tr + 250 + $urandom_range(0, 3));
         drive_edge(1'b0, tf);
         inject(tf + 80 + (i * 29) % 70, (i % 3 == 2) ? 3 : 1);
         wait_until(tf + 250 + $urandom_range(0, 3));
      end

      drive_edge(1'b1, tr);
      wait_until(tr + 600);
      check(sb.size() == 0, "R4 no missing edges", longint'(sb.size()), 0);
      check(locked === 1'b1, "R5 lock before stall", longint'(locked), 1);
      mon_on = 1'b0;
      wait_until(tr + 1300);
      @(negedge clk_fast);
      check(locked === 1'b0, "R6 lock drops on stall", longint'(locked), 0);
      check(clk_clean === 1'b0, "R6 clean held low", longint'(clk_clean), 0);
      check(n_glitch_obs == n_glitch_exp, "R3 glitch pulse count",
            longint'(n_glitch_obs), longint'(n_glitch_exp));

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule